// File: doc/BRIEF.md
# Domain-Based Memory Protection Unit

This block stands between a small processor and its memories and vets every memory request against an access matrix. The address space is cut into a power-of-two number of equal blocks. Each block owns a permission word with one bit per basic protection domain. A separate active-domain word says which domains the running task currently holds. When a request arrives, its upper address bits pick a block. If the active-domain word shares at least one set bit with that block's permission word, the request goes on to memory in the same cycle. If not, it is held back and a protection fault is raised instead.

A command port changes the protection state. It can load the active-domain word, add one domain to it (rights amplification), grant a block to a domain, or revoke a block from a domain. A task may only grant or revoke rights on a block it can already reach through its own active domain. Each command is acknowledged by a one-cycle done pulse that carries an error flag. All operations are idempotent. With the default eight domains, the state costs one byte per block plus one byte for the active word.

Top module: `dmpu_top`

## Requirements
- R1: After reset the active-domain word equals RST_ACTIVE (default 8'h01, domain 0), and every block's permission word equals RST_PERM (default 8'h01), so domain 0 can reach every block.
- R2: The block index is the upper BLK_W bits of `req_addr`, and the lower ADDR_W-BLK_W bits are the offset. A forwarded request presents `req_addr` and `req_write` unchanged on `mem_addr` and `mem_write`.
- R3: In the same cycle as `req_valid`, `mem_valid` is high exactly when (active AND permission word of the addressed block) is nonzero. Otherwise `prot_fault` is high. With `req_valid` low, both outputs are low.
- R4: Command op 2'b00 (set) loads the active-domain word with `cmd_domain`, whatever its value. Several set bits form the union of those domains, and all ones reaches every block that has any permission bit set.
- R5: Command op 2'b01 (grant) sets bit k of block `cmd_block`'s word, where `cmd_domain` is one-hot at bit k. It succeeds only if the active word shares a bit with that block's word. Otherwise it reports an error and changes nothing.
- R6: Command op 2'b10 (revoke) clears bit k of block `cmd_block`'s word. It uses the same held-access check and the same error behaviour as grant.
- R7: For grant, revoke and amplify, a `cmd_domain` that is not exactly one-hot (zero, or more than one bit set) reports an error and leaves every permission word and the active word unchanged.
- R8: Command op 2'b11 (amplify) ORs a one-hot `cmd_domain` into the active word, with no block check.
- R9: `cmd_ready` is high whenever reset is released, and a command is accepted on any clock edge where `cmd_valid` is high. `rsp_done` pulses high for one cycle in the cycle after acceptance. `rsp_error` is only ever high together with `rsp_done`. A command's state change is visible to accesses from the next cycle on.
- R10: Repeating a grant, revoke or set leaves the same state as applying it once, and a repeat that passes the checks reports success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor memory request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_write | output | 1 | Forwarded write flag |
| mem_addr | output | ADDR_W | Forwarded address |
| prot_fault | output | 1 | Protection violation on the current request |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 00 set, 01 grant, 10 revoke, 11 amplify |
| cmd_block | input | BLK_W | Target block of grant or revoke |
| cmd_domain | input | DOM_N | Domain value or one-hot target domain |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Command failed, qualified by rsp_done |

## Verification
Some properties are checked by assertions on every cycle. A request either forwards or faults, never both, and an idle request does neither. A forwarded address is passed through unchanged. Every accepted command yields exactly one done pulse in the next cycle. A failed command leaves the whole protection state untouched, and no cycle changes more than one permission bit. Only the bench's reference model and scenarios can show which domain actually ends up holding which block. They also show that the block index comes from the top address bits, that amplification and union domains open the expected blocks, and that the held-access rule rejects grants and revokes from outsiders.

// File: rtl/dmpu_pkg.sv
package dmpu_pkg;
   typedef enum logic [1:0] {
      OP_SET     = 2'b00,
      OP_GRANT   = 2'b01,
      OP_REVOKE  = 2'b10,
      OP_AMPLIFY = 2'b11
   } dmpu_op_e;

   function automatic logic is_onehot(input logic [63:0] v);
      return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
   endfunction
endpackage

// File: rtl/dmpu_perm_bank.sv
module dmpu_perm_bank #(
   parameter int                NBLK     = 8,
   parameter int                DOM_N    = 8,
   parameter logic [DOM_N-1:0]  RST_PERM = 1,
   localparam int               BW       = $clog2(NBLK)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wr_set,
   input  logic [BW-1:0]           wr_blk,
   input  logic [DOM_N-1:0]        wr_dom,
   input  logic [BW-1:0]           rd_blk_a,
   output logic [DOM_N-1:0]        rd_perm_a,
   input  logic [BW-1:0]           rd_blk_b,
   output logic [DOM_N-1:0]        rd_perm_b,
   output logic [NBLK*DOM_N-1:0]   perm_flat
);
   logic [DOM_N-1:0] regs [NBLK];

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[b] <= RST_PERM;
         else if (wr_en && (wr_blk == BW'(b)))
            regs[b] <= wr_set ? (regs[b] | wr_dom) : (regs[b] & ~wr_dom);
      end
      assign perm_flat[b*DOM_N +: DOM_N] = regs[b];
   end

   assign rd_perm_a = regs[rd_blk_a];
   assign rd_perm_b = regs[rd_blk_b];

   // R5/R6: a single command touches at most one matrix bit
   assert_one_bit_per_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(perm_flat ^ $past(perm_flat)) <= 1);
endmodule

// File: rtl/dmpu_access_gate.sv
module dmpu_access_gate #(
   parameter  int ADDR_W = 16,
   parameter  int BLK_W  = 3,
   parameter  int DOM_N  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DOM_N-1:0]   active,
   input  logic [DOM_N-1:0]   blk_perm,
   output logic [BLK_W-1:0]   req_blk,
   output logic               mem_valid,
   output logic               mem_write,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               prot_fault
);
   logic allowed;

   assign req_blk    = req_addr[ADDR_W-1 -: BLK_W];
   assign allowed    = |(active & blk_perm);
   assign mem_valid  = req_valid & allowed;
   assign prot_fault = req_valid & ~allowed;
   assign mem_write  = req_write & mem_valid;
   assign mem_addr   = req_addr;

   assert_fwd_xor_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (mem_valid != prot_fault));
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_valid && !prot_fault));
   assert_addr_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr == req_addr && mem_write == req_write));
endmodule

// File: rtl/dmpu_cmd_unit.sv
module dmpu_cmd_unit
   import dmpu_pkg::*;
#(
   parameter int                DOM_N      = 8,
   parameter logic [DOM_N-1:0]  RST_ACTIVE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [DOM_N-1:0]   cmd_domain,
   input  logic [DOM_N-1:0]   blk_perm,
   output logic               cmd_ready,
   output logic [DOM_N-1:0]   active,
   output logic               wr_en,
   output logic               wr_set,
   output logic [DOM_N-1:0]   wr_dom,
   output logic               rsp_done,
   output logic               rsp_error
);
   dmpu_op_e op;
   logic     accept, one_hot, held, ok;

   assign op        = dmpu_op_e'(cmd_op);
   assign cmd_ready = rst_n;
   assign accept    = cmd_valid & cmd_ready;
   assign one_hot   = is_onehot(64'(cmd_domain));
   assign held      = |(active & blk_perm);

   always_comb begin
      unique case (op)
         OP_SET:               ok = 1'b1;
         OP_GRANT, OP_REVOKE:  ok = one_hot & held;
         OP_AMPLIFY:           ok = one_hot;
         default:              ok = 1'b0;
      endcase
   end

   assign wr_en  = accept & ok & ((op == OP_GRANT) | (op == OP_REVOKE));
   assign wr_set = (op == OP_GRANT);
   assign wr_dom = cmd_domain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= RST_ACTIVE;
         rsp_done  <= 1'b0;
         rsp_error <= 1'b0;
      end else begin
         rsp_done  <= accept;
         rsp_error <= accept & ~ok;
         if (accept && ok) begin
            if (op == OP_SET)
               active <= cmd_domain;
            else if (op == OP_AMPLIFY)
               active <= active | cmd_domain;
         end
      end
   end

   assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_done);
   assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_done);
   assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> rsp_done);
   assert_amplify_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_error && $past(cmd_op) == 2'b11)
         |-> ((active & $past(active)) == $past(active)
              && $countones(active ^ $past(active)) <= 1));
endmodule

// File: rtl/dmpu_top.sv
module dmpu_top #(
   parameter int                ADDR_W     = 16,
   parameter int                BLK_W      = 3,
   parameter int                DOM_N      = 8,
   parameter logic [DOM_N-1:0]  RST_ACTIVE = 1,
   parameter logic [DOM_N-1:0]  RST_PERM   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               mem_valid,
   output logic               mem_write,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               prot_fault,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [1:0]         cmd_op,
   input  logic [BLK_W-1:0]   cmd_block,
   input  logic [DOM_N-1:0]   cmd_domain,
   output logic               rsp_done,
   output logic               rsp_error
);
   localparam int NBLK = 1 << BLK_W;

   if (BLK_W < 1 || BLK_W >= ADDR_W) begin : g_bad_blk
      $error("dmpu_top: BLK_W must lie in 1..ADDR_W-1");
   end
   if (DOM_N < 1 || DOM_N > 64) begin : g_bad_dom
      $error("dmpu_top: DOM_N must lie in 1..64");
   end

   logic [DOM_N-1:0]       active, acc_perm, cmd_perm, wr_dom;
   logic [BLK_W-1:0]       acc_blk;
   logic                   wr_en, wr_set;
   logic [NBLK*DOM_N-1:0]  perm_flat;

   dmpu_perm_bank #(.NBLK(NBLK), .DOM_N(DOM_N), .RST_PERM(RST_PERM)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_set(wr_set), .wr_blk(cmd_block), .wr_dom(wr_dom),
      .rd_blk_a(acc_blk), .rd_perm_a(acc_perm),
      .rd_blk_b(cmd_block), .rd_perm_b(cmd_perm),
      .perm_flat(perm_flat)
   );

   dmpu_access_gate #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DOM_N(DOM_N)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .active(active), .blk_perm(acc_perm), .req_blk(acc_blk),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .prot_fault(prot_fault)
   );

   dmpu_cmd_unit #(.DOM_N(DOM_N), .RST_ACTIVE(RST_ACTIVE)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_domain(cmd_domain),
      .blk_perm(cmd_perm), .cmd_ready(cmd_ready), .active(active),
      .wr_en(wr_en), .wr_set(wr_set), .wr_dom(wr_dom),
      .rsp_done(rsp_done), .rsp_error(rsp_error)
   );

   // R5, R6, R7: a rejected command leaves the protection state as it was
   assert_fail_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> ($stable(perm_flat) && $stable(active)));
endmodule

// File: tb/dmpu_top_tb.sv
module dmpu_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic        mem_valid, mem_write, prot_fault;
   logic [15:0] mem_addr;
   logic        cmd_valid = 1'b0, cmd_ready;
   logic [1:0]  cmd_op = '0;
   logic [2:0]  cmd_block = '0;
   logic [7:0]  cmd_domain = '0;
   logic        rsp_done, rsp_error;

   int checks = 0, failures = 0;
   bit finished = 0;

   // behavioural reference state
   bit [7:0] m_perm [8];
   bit [7:0] m_active;
   bit       e_done, e_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmpu_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .prot_fault(prot_fault),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_block(cmd_block), .cmd_domain(cmd_domain),
      .rsp_done(rsp_done), .rsp_error(rsp_error)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit one_hot(bit [7:0] d);
      return (d != 0) && ((d & (d - 8'd1)) == 0);
   endfunction

   // one clock: drive at negedge, compare, then advance the model at posedge
   task automatic step(string tag, bit cv, bit [1:0] op, int blk, bit [7:0] dom,
                       bit rv, bit [15:0] addr, bit wr = 0);
      bit fwd, ok, held;
      bit [7:0] n_active;
      @(negedge clk);
      cmd_valid = cv; cmd_op = op; cmd_block = 3'(blk); cmd_domain = dom;
      req_valid = rv; req_addr = addr; req_write = wr;
      #1;
      fwd = rv && ((m_active & m_perm[addr[15:13]]) != 0);
      chk({tag, "/R3"}, "mem_valid", mem_valid, fwd);
      chk({tag, "/R3"}, "prot_fault", prot_fault, rv && !fwd);
      if (fwd) begin
         chk({tag, "/R2"}, "mem_addr", mem_addr, addr);
         chk({tag, "/R2"}, "mem_write", mem_write, wr);
      end
      chk({tag, "/R9"}, "cmd_ready", cmd_ready, 1'b1);
      chk({tag, "/R9"}, "rsp_done", rsp_done, e_done);
      chk({tag, "/R9"}, "rsp_error", rsp_error, e_err);
      held = (m_active & m_perm[blk]) != 0;
      case (op)
         2'b00:   ok = 1;
         2'b11:   ok = one_hot(dom);
         default: ok = one_hot(dom) && held;
      endcase
      n_active = m_active;
      @(posedge clk);
      e_done = cv;
      e_err  = cv && !ok;
      if (cv && ok) begin
         case (op)
            2'b00: n_active = dom;
            2'b01: m_perm[blk] = m_perm[blk] | dom;
            2'b10: m_perm[blk] = m_perm[blk] & ~dom;
            2'b11: n_active = m_active | dom;
         endcase
         m_active = n_active;
      end
   endtask

   task automatic cmd(string tag, bit [1:0] op, int blk, bit [7:0] dom);
      step(tag, 1, op, blk, dom, 0, 16'h0);
   endtask

   task automatic probe_all(string tag);
      for (int b = 0; b < 8; b++) step(tag, 0, 0, 0, 0, 1, {3'(b), 13'h0A5}, b[0]);
   endtask

   initial begin
      for (int b = 0; b < 8; b++) m_perm[b] = 8'h01;
      m_active = 8'h01; e_done = 0; e_err = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "rsp_done in reset", rsp_done, 1'b0);
      rst_n = 1'b1;

      probe_all("R1");                          // domain 0 reaches every block
      cmd("R4", 2'b00, 0, 8'h02);               // activate domain 1
      probe_all("R4");                          // all fault
      cmd("R5", 2'b01, 2, 8'h02);               // grant not held: error
      probe_all("R5");
      cmd("R4", 2'b00, 0, 8'h01);
      cmd("R5", 2'b01, 2, 8'h02);               // grant block2 to domain1
      cmd("R10", 2'b01, 2, 8'h02);              // repeat: success, same state
      cmd("R4", 2'b00, 0, 8'h02);
      probe_all("R10");
      cmd("R6", 2'b10, 2, 8'h01);               // domain1 revokes domain0 from block2
      cmd("R10", 2'b10, 2, 8'h01);
      cmd("R4", 2'b00, 0, 8'h01);
      probe_all("R6");
      cmd("R6", 2'b10, 2, 8'h02);               // domain0 no longer holds block2: error
      cmd("R7", 2'b01, 1, 8'h03);               // two bits
      cmd("R7", 2'b01, 1, 8'h00);               // zero
      cmd("R7", 2'b11, 0, 8'h06);               // amplify two bits
      probe_all("R7");
      cmd("R4", 2'b00, 0, 8'h02);
      cmd("R8", 2'b11, 0, 8'h01);               // union of domain 0 and 1
      probe_all("R8");
      cmd("R4", 2'b00, 0, 8'hFF);               // all ones
      cmd("R10", 2'b00, 0, 8'hFF);
      probe_all("R4");
      cmd("R4", 2'b00, 0, 8'h00);
      probe_all("R4");
      // R2: boundary between block 1 and block 2 under domain 1 only
      cmd("R2", 2'b00, 0, 8'h02);
      step("R2", 0, 0, 0, 0, 1, 16'h3FFF, 1);
      step("R2", 0, 0, 0, 0, 1, 16'h4000, 1);
      step("R2", 0, 0, 0, 0, 1, 16'h5FFF, 0);
      // R9: command and access in one cycle, access sees the old state
      step("R9", 1, 2'b00, 0, 8'h01, 1, 16'h4000);
      step("R9", 1, 2'b00, 0, 8'h02, 1, 16'h4000);
      step("R9", 0, 0, 0, 0, 1, 16'h4000);
      // mixed random traffic
      for (int i = 0; i < 400; i++)
         step("R3", ($urandom % 3) == 0, 2'($urandom), $urandom % 8,
              (($urandom % 4) == 0) ? 8'($urandom) : 8'(1 << ($urandom % 8)),
              1'($urandom), 16'($urandom), 1'($urandom));
      step("R9", 0, 0, 0, 0, 0, 16'h0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule